// File: doc/BRIEF.md
# I/O Translation Unit Control and Fault Register Block

This block is the software-visible register set of an I/O address translation unit. A 32-bit word bus reads and writes the registers:
- a control word whose range field sets the base of the device-address window;
- the translation-table base;
- two flush registers, one for the whole TLB and one for a single page;
- one configuration word for each of four bus slots;
- an arbitration enable word;
- a fault status word and a fault address word.

The window base and the table base are driven straight to the translator. When the translator finds an invalid or write-protected page, it raises a one-cycle fault report that carries the faulting address and a read flag. The block then writes a fixed-format status word and the page-aligned address into the fault registers.

Top module: `iommu_regs`

## Requirements
- R1: After reset the control register reads 0x0500_0000 (the version code), every other register reads 0, and `win_base` and `tbl_base` are 0.
- R2: A write to the control register (byte offset 0x000) stores the written value ANDed with 0x0000_001D and ORed with the version code 0x0500_0000. Bits 4:2 are the range field.
- R3: A control write with range code k (0 to 7, written to bits 4:2) makes `win_base` equal 0xFF00_0000 shifted left by k, on the clock edge that takes the write. Code 0 is a 16 MB window (0xFF00_0000) and code 7 is a 2 GB window (0x8000_0000). No other access changes `win_base`.
- R4: The slot configuration registers sit at byte offsets 0x1010, 0x1014, 0x1018 and 0x101C. A write to any of them keeps only the bits in mask 0x0001_0003: bit 0 is translation bypass, bit 1 allows 8-byte bursts, and bit 16 is the third writable bit.
- R5: A write to the arbitration enable register (0x2000) stores the value ANDed with 0x0000_001F and ORed with the module ID 0x0008_0000.
- R6: The table base (0x004), TLB flush (0x014) and page flush (0x018) registers store the written value unchanged. `tbl_base` always equals the stored table base.
- R7: A fault report sets the fault status register (0x1000) to 0xC082_0000: bit 31 error summary, bit 30 late error, bits 23:20 equal to 8, and bit 17 address valid. When `flt_read` is high, bit 18 is also set, giving 0xC086_0000.
- R8: A fault report loads the fault address register (0x1004) with `flt_addr` with its low 12 bits cleared.
- R9: If a bus write to a fault register and a fault report fall in the same cycle, the fault report's value is stored.
- R10: A read returns its data on `bus_rdata` with `bus_rvalid` high one cycle after the request. Unmapped offsets read as 0, and writes to them change no register.
- R11: With no fault report in the same cycle, a bus write to either fault register stores the value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| flt_valid | input | 1 | One-cycle fault report from the translator |
| flt_addr | input | 32 | Faulting device address |
| flt_read | input | 1 | Faulting access was a read |
| win_base | output | 32 | Device-address window base for the translator |
| tbl_base | output | 32 | Translation-table base for the translator |

## Verification
All results are registered once. A write or fault report that is sampled on one edge appears in the registers, and on `win_base` and `tbl_base`, right after that edge. Read data arrives one cycle after the request, together with `bus_rvalid`. The driver applies stimulus on falling edges. Each read pushes its expected word into a queue, and a monitor on the next falling edge pops that entry when `bus_rvalid` is high, so every comparison lands exactly one cycle after its request. The exported bases are sampled on the falling edge that follows the write, and the queue must be empty at the end.

// File: rtl/iommu_regs_pkg.sv
package iommu_regs_pkg;
    localparam int DW = 32;

    // register byte offsets
    localparam logic [13:0] OFS_CTRL   = 14'h0000;
    localparam logic [13:0] OFS_TBASE  = 14'h0004;
    localparam logic [13:0] OFS_TLBFL  = 14'h0014;
    localparam logic [13:0] OFS_PGFL   = 14'h0018;
    localparam logic [13:0] OFS_FSTAT  = 14'h1000;
    localparam logic [13:0] OFS_FADDR  = 14'h1004;
    localparam logic [13:0] OFS_SLOT0  = 14'h1010;
    localparam logic [13:0] OFS_ARB    = 14'h2000;

    // fault status fields
    localparam logic [DW-1:0] FS_SUMMARY = 32'h8000_0000;
    localparam logic [DW-1:0] FS_LATE    = 32'h4000_0000;
    localparam logic [DW-1:0] FS_FIXED8  = 32'h0080_0000;
    localparam logic [DW-1:0] FS_RDOP    = 32'h0004_0000;
    localparam logic [DW-1:0] FS_AVALID  = 32'h0002_0000;
endpackage

// File: rtl/iommu_win_decode.sv
module iommu_win_decode #(
    parameter int          CODE_W   = 3,
    parameter logic [31:0] MIN_BASE = 32'hFF00_0000
) (
    input  logic [CODE_W-1:0] range_code,
    output logic [31:0]       base
);
    // each step up in the code doubles the window, pulling the base down
    always_comb begin
        base = MIN_BASE << range_code;
    end
endmodule

// File: rtl/iommu_fault_fmt.sv
module iommu_fault_fmt
    import iommu_regs_pkg::*;
#(
    parameter int PAGE_SHIFT = 12
) (
    input  logic [DW-1:0] addr,
    input  logic          is_read,
    output logic [DW-1:0] status,
    output logic [DW-1:0] page_addr
);
    localparam logic [DW-1:0] PAGE_MASK = (DW'(1) << PAGE_SHIFT) - DW'(1);

    always_comb begin
        status = FS_SUMMARY | FS_LATE | FS_FIXED8 | FS_AVALID;
        if (is_read) begin
            status = status | FS_RDOP;
        end
        page_addr = addr & ~PAGE_MASK;
    end
endmodule

// File: rtl/iommu_regs.sv
module iommu_regs
    import iommu_regs_pkg::*;
#(
    parameter int          ADDR_W     = 14,
    parameter int          NSLOT      = 4,
    parameter int          PAGE_SHIFT = 12,
    parameter int          RANGE_LSB  = 2,
    parameter int          RANGE_W    = 3,
    parameter logic [31:0] VERSION    = 32'h0500_0000,
    parameter logic [31:0] CTRL_WMASK = 32'h0000_001D,
    parameter logic [31:0] SLOT_WMASK = 32'h0001_0003,
    parameter logic [31:0] ARB_WMASK  = 32'h0000_001F,
    parameter logic [31:0] MODULE_ID  = 32'h0008_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              flt_valid,
    input  logic [31:0]       flt_addr,
    input  logic              flt_read,
    output logic [31:0]       win_base,
    output logic [31:0]       tbl_base
);
    localparam int SLOT_STRIDE = 4;

    typedef struct packed {
        logic [DW-1:0]            ctrl;
        logic [DW-1:0]            tbase;
        logic [DW-1:0]            tlbfl;
        logic [DW-1:0]            pgfl;
        logic [NSLOT-1:0][DW-1:0] slot;
        logic [DW-1:0]            arb;
        logic [DW-1:0]            fstat;
        logic [DW-1:0]            faddr;
        logic [DW-1:0]            win;
        logic [DW-1:0]            rdata;
        logic                     rvalid;
    } regs_t;

    regs_t st_d, st_q;

    logic wr_en, rd_en;
    logic [NSLOT-1:0] slot_hit;
    logic [DW-1:0] win_dec, flt_stat, flt_page, rd_mux;

    assign wr_en = bus_req & bus_we;
    assign rd_en = bus_req & ~bus_we;

    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot_hit
        assign slot_hit[gi] = (bus_addr == ADDR_W'(OFS_SLOT0 + gi * SLOT_STRIDE));
    end

    iommu_win_decode #(
        .CODE_W   (RANGE_W),
        .MIN_BASE (32'hFF00_0000)
    ) u_win_dec (
        .range_code (bus_wdata[RANGE_LSB +: RANGE_W]),
        .base       (win_dec)
    );

    iommu_fault_fmt #(
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_flt_fmt (
        .addr      (flt_addr),
        .is_read   (flt_read),
        .status    (flt_stat),
        .page_addr (flt_page)
    );

    // read selection
    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_CTRL):  rd_mux = st_q.ctrl;
            ADDR_W'(OFS_TBASE): rd_mux = st_q.tbase;
            ADDR_W'(OFS_TLBFL): rd_mux = st_q.tlbfl;
            ADDR_W'(OFS_PGFL):  rd_mux = st_q.pgfl;
            ADDR_W'(OFS_ARB):   rd_mux = st_q.arb;
            ADDR_W'(OFS_FSTAT): rd_mux = st_q.fstat;
            ADDR_W'(OFS_FADDR): rd_mux = st_q.faddr;
            default:            rd_mux = '0;
        endcase
        for (int i = 0; i < NSLOT; i++) begin
            if (slot_hit[i]) begin
                rd_mux = st_q.slot[i];
            end
        end
    end

    // next-state
    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        if (wr_en) begin
            unique case (bus_addr)
                ADDR_W'(OFS_CTRL): begin
                    st_d.ctrl = (bus_wdata & CTRL_WMASK) | VERSION;
                    st_d.win  = win_dec;
                end
                ADDR_W'(OFS_TBASE): st_d.tbase = bus_wdata;
                ADDR_W'(OFS_TLBFL): st_d.tlbfl = bus_wdata;
                ADDR_W'(OFS_PGFL):  st_d.pgfl  = bus_wdata;
                ADDR_W'(OFS_ARB):   st_d.arb   = (bus_wdata & ARB_WMASK) | MODULE_ID;
                ADDR_W'(OFS_FSTAT): st_d.fstat = bus_wdata;
                ADDR_W'(OFS_FADDR): st_d.faddr = bus_wdata;
                default: ;
            endcase
            for (int i = 0; i < NSLOT; i++) begin
                if (slot_hit[i]) begin
                    st_d.slot[i] = bus_wdata & SLOT_WMASK;
                end
            end
        end
        // the fault report takes precedence over a bus write
        if (flt_valid) begin
            st_d.fstat = flt_stat;
            st_d.faddr = flt_page;
        end
        if (rd_en) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ctrl <= VERSION;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;
    assign win_base   = st_q.win;
    assign tbl_base   = st_q.tbase;

    // ---------------- assertions ----------------
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_W'(OFS_CTRL)) |=>
            (st_q.ctrl == (($past(bus_wdata) & CTRL_WMASK) | VERSION)));

    p_win_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_W'(OFS_CTRL)) |=>
            (win_base == (32'hFF00_0000 << $past(bus_wdata[RANGE_LSB +: RANGE_W]))));

    p_win_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bus_addr == ADDR_W'(OFS_CTRL)) |=> $stable(win_base));

    p_fault_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> (st_q.fstat[31:30] == 2'b11 && st_q.fstat[23:20] == 4'h8
                       && st_q.fstat[17] && st_q.fstat[18] == $past(flt_read)));

    p_fault_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> (st_q.faddr[PAGE_SHIFT-1:0] == '0 &&
                       st_q.faddr[31:PAGE_SHIFT] == $past(flt_addr[31:PAGE_SHIFT])));

    p_read_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> bus_rvalid);

    p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !bus_rvalid);
endmodule

// File: tb/tb_iommu_regs.sv
`timescale 1ns/1ps
module tb_iommu_regs;
    localparam logic [31:0] VER   = 32'h0500_0000;
    localparam logic [31:0] MODID = 32'h0008_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        flt_valid = 1'b0, flt_read = 1'b0;
    logic [31:0] flt_addr = '0;
    logic [31:0] win_base, tbl_base;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    iommu_regs dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_read(flt_read),
        .win_base(win_base), .tbl_base(tbl_base)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.exp = exp; e.tag = tag;
        @(negedge clk);
        sb.push_back(e);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic fault(input logic [31:0] a, input logic isrd, input logic with_wr,
                         input logic [13:0] wa, input logic [31:0] wv);
        @(negedge clk);
        flt_valid = 1'b1; flt_addr = a; flt_read = isrd;
        if (with_wr) begin
            bus_req = 1'b1; bus_we = 1'b1; bus_addr = wa; bus_wdata = wv;
        end
        @(negedge clk);
        flt_valid = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    endtask

    // monitor: read data is due one cycle after the request
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb.size() == 0) begin
                check("R10 unexpected rvalid", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, bus_rdata, e.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 win_base", win_base, 32'h0);
        check("R1 tbl_base", tbl_base, 32'h0);
        rd(14'h0000, VER, "R1 ctrl");
        rd(14'h0004, 32'h0, "R1 tbase");
        rd(14'h1000, 32'h0, "R1 fstat");
        rd(14'h2000, 32'h0, "R1 arb");
        rd(14'h1014, 32'h0, "R1 slot1");

        // R2 control masking
        wr(14'h0000, 32'hFFFF_FFFF);
        check("R3 code7", win_base, 32'h8000_0000);
        rd(14'h0000, 32'h0500_001D, "R2 ctrl all-ones");
        wr(14'h0000, 32'h0000_0000);
        rd(14'h0000, VER, "R2 ctrl zero keeps version");

        // R3 every range code
        for (int k = 0; k < 8; k++) begin
            wr(14'h0000, (32'(k) << 2) | 32'h1);
            check("R3 range code", win_base, 32'hFF00_0000 << k);
        end
        // R3 other writes leave win_base alone
        wr(14'h0004, 32'h1234_5670);
        check("R3 win unchanged", win_base, 32'h8000_0000);

        // R6 plain registers
        check("R6 tbl_base", tbl_base, 32'h1234_5670);
        rd(14'h0004, 32'h1234_5670, "R6 tbase");
        wr(14'h0014, 32'hCAFE_F00D);
        wr(14'h0018, 32'h0BAD_BEEF);
        rd(14'h0014, 32'hCAFE_F00D, "R6 tlb flush");
        rd(14'h0018, 32'h0BAD_BEEF, "R6 page flush");

        // R4 slot registers
        for (int i = 0; i < 4; i++) begin
            wr(14'h1010 + 14'(4 * i), 32'hA5A5_5A5A ^ (32'h1 << i) ^ 32'hFFFF_0000);
        end
        for (int i = 0; i < 4; i++) begin
            rd(14'h1010 + 14'(4 * i),
               (32'hA5A5_5A5A ^ (32'h1 << i) ^ 32'hFFFF_0000) & 32'h0001_0003, "R4 slot mask");
        end

        // R5 arbitration enable
        wr(14'h2000, 32'hFFFF_FFFF);
        rd(14'h2000, 32'h0000_001F | MODID, "R5 arb all-ones");
        wr(14'h2000, 32'h0000_0005);
        rd(14'h2000, 32'h0000_0005 | MODID, "R5 arb pattern");

        // R11 plain writes to fault registers
        wr(14'h1000, 32'h1357_9BDF);
        wr(14'h1004, 32'h2468_ACE0);
        rd(14'h1000, 32'h1357_9BDF, "R11 fstat write");
        rd(14'h1004, 32'h2468_ACE0, "R11 faddr write");

        // R7 R8 fault reports
        fault(32'h1234_5ABC, 1'b1, 1'b0, 14'h0, 32'h0);
        rd(14'h1000, 32'hC086_0000, "R7 read fault status");
        rd(14'h1004, 32'h1234_5000, "R8 read fault addr");
        fault(32'hFFFF_FFFF, 1'b0, 1'b0, 14'h0, 32'h0);
        rd(14'h1000, 32'hC082_0000, "R7 write fault status");
        rd(14'h1004, 32'hFFFF_F000, "R8 write fault addr");

        // R9 fault beats simultaneous bus write
        fault(32'h0000_1FFF, 1'b1, 1'b1, 14'h1000, 32'hDEAD_BEEF);
        rd(14'h1000, 32'hC086_0000, "R9 fstat precedence");
        fault(32'h0ABC_D123, 1'b0, 1'b1, 14'h1004, 32'hDEAD_BEEF);
        rd(14'h1004, 32'h0ABC_D000, "R9 faddr precedence");

        // R10 unmapped offsets
        wr(14'h0100, 32'hFFFF_FFFF);
        rd(14'h0100, 32'h0, "R10 unmapped read");
        rd(14'h0004, 32'h1234_5670, "R10 unmapped write ignored");
        check("R10 win after unmapped", win_base, 32'h8000_0000);

        repeat (3) @(negedge clk);
        check("R10 all reads answered", 32'(sb.size()), 32'h0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule